// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table held in memory. A client presents a virtual address and an access direction. When translation is enabled, the walker reads one directory word and then one page-table word over a simple word-read port. It then returns exactly one outcome: a physical address, a page fault, or a bus error. A fault or bus error carries the faulting virtual address and the direction of the access.

The virtual address is split into three fields. Bits 31:22 select a directory slot and bits 21:12 select a page-table slot. Bits 11:0 are the byte offset, which is carried unchanged into the result. Every table holds 1024 entries of four bytes, so each table fills one 4 KiB frame. The directory frame number is supplied by the client.

Only one walk is handled at a time. When translation is disabled, a request returns its own address one cycle after acceptance and makes no memory read.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after it is released, the walker is idle: `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0.
- R2: A request accepted with `paging_en`=0 gives `rsp_valid` in the next cycle with `rsp_addr` equal to the request address, `rsp_fault`=0 and `rsp_bus_err`=0, and makes no memory read.
- R3: The first read of a translated request goes to `{dir_frame, 12'h000} + 4*vaddr[31:22]`. Both `dir_frame` and `paging_en` are sampled at acceptance, and later changes do not affect the walk in flight.
- R4: A directory word whose bit 0 (valid) is 0 ends the walk with a page fault (`rsp_fault`=1, `rsp_addr`=vaddr, `rsp_write`=direction), and no second read is made.
- R5: The second read goes to `{dir_word[31:12], 12'h000} + 4*vaddr[21:12]`.
- R6: A page word whose bit 0 (valid) is 0 ends the walk with a page fault.
- R7: A read needs page-word bit 1 (readable) and a write needs page-word bit 2 (writable). A missing permission raises a page fault. Page-word bits 11:3 (cache attributes) have no effect on the result.
- R8: A successful walk returns `rsp_addr` = `{page_word[31:12], vaddr[11:0]}` with `rsp_fault`=0 and `rsp_bus_err`=0.
- R9: A response with `mem_rsp_err`=1 at either level ends the walk with `rsp_bus_err`=1, `rsp_fault`=0 and `rsp_addr`=vaddr, whatever the data word holds.
- R10: `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen. Only one response is taken after each acceptance, and a response offered before acceptance is ignored.
- R11: `req_ready` is low from acceptance through the cycle in which the result is shown. `rsp_valid` lasts one cycle, and exactly one result is produced per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request taken when both are high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| paging_en | input | 1 | Translation enabled; 0 passes the address through |
| dir_frame | input | 20 | Frame number of the directory table |
| mem_rd_valid | output | 1 | Table word read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table word |
| mem_rsp_err | input | 1 | Read completed with an error |
| rsp_valid | output | 1 | Outcome shown for one cycle |
| rsp_addr | output | 32 | Physical address, or faulting virtual address |
| rsp_write | output | 1 | Direction of the finished request |
| rsp_fault | output | 1 | Page fault (invalid entry or missing permission) |
| rsp_bus_err | output | 1 | Table read returned an error |

## Verification
Two functions of the walker can fall in the same cycle. In the first case, a response that carries an error flag also carries a data word that would, on its own, be an invalid entry. The bench places zero words at erroring addresses at both levels and expects a bus error, never a page fault. In the second case, a new request is held high while a walk finishes, and it overlaps the cycle in which the result is shown. The bench expects the pending result unchanged, with no second result and no new read. A response offered before the read is accepted is also driven, and the outcome must be unaffected.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE  = 3'd0,
        WALK_DIR   = 3'd1,
        WALK_LEAF  = 3'd2,
        WALK_DONE  = 3'd3,
        WALK_FAULT = 3'd4
    } walk_state_e;

    localparam int ENTRY_BYTES = 4;
    localparam int VALID_BIT   = 0;
    localparam int READ_BIT    = 1;
    localparam int WRITE_BIT   = 2;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 10
) (
    input  logic [ADDR_W-PAGE_BITS-1:0] table_base,
    input  logic [IDX_W-1:0]            index,
    output logic [ADDR_W-1:0]           entry_addr
);
    localparam int SCALE_SH = $clog2(pt_walk_pkg::ENTRY_BYTES);

    always_comb begin
        entry_addr = {table_base, {PAGE_BITS{1'b0}}} + (ADDR_W'(index) << SCALE_SH);
    end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter bit IS_LEAF   = 1'b0
) (
    input  logic [ADDR_W-1:0]           entry,
    input  logic                        is_write,
    output logic                        usable,
    output logic [ADDR_W-PAGE_BITS-1:0] next_base
);
    logic perm_ok;
    logic attr_unused;

    generate
        if (IS_LEAF) begin : g_leaf
            // leaf level: direction must be granted by the entry
            assign perm_ok     = is_write ? entry[WRITE_BIT] : entry[READ_BIT];
            assign attr_unused = ^entry[PAGE_BITS-1:WRITE_BIT+1];
        end else begin : g_dir
            // directory level: only the valid flag matters
            assign perm_ok     = 1'b1;
            assign attr_unused = ^{is_write, entry[PAGE_BITS-1:VALID_BIT+1]};
        end
    endgenerate

    assign usable    = entry[VALID_BIT] & perm_ok;
    assign next_base = entry[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter  int DIR_BITS  = 10,
    parameter  int TBL_BITS  = 10,
    parameter  int PAGE_BITS = 12,
    localparam int ADDR_W    = DIR_BITS + TBL_BITS + PAGE_BITS,
    localparam int BASE_W    = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              paging_en,
    input  logic [BASE_W-1:0] dir_frame,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic              rsp_fault,
    output logic              rsp_bus_err
);

    typedef struct packed {
        walk_state_e       st;
        logic              issued;
        logic              write;
        logic              fault;
        logic              bus_err;
        logic [ADDR_W-1:0] va;
        logic [BASE_W-1:0] base;
        logic [ADDR_W-1:0] out_addr;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [ADDR_W-1:0] dir_addr, leaf_addr;
    logic              dir_ok, leaf_ok, entry_ok;
    logic [BASE_W-1:0] dir_next, leaf_next, next_base;

    pt_entry_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(DIR_BITS)) i_dir_addr (
        .table_base (q.base),
        .index      (q.va[ADDR_W-1 -: DIR_BITS]),
        .entry_addr (dir_addr)
    );

    pt_entry_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(TBL_BITS)) i_leaf_addr (
        .table_base (q.base),
        .index      (q.va[PAGE_BITS +: TBL_BITS]),
        .entry_addr (leaf_addr)
    );

    pt_entry_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_LEAF(1'b0)) i_dir_check (
        .entry     (mem_rsp_data),
        .is_write  (q.write),
        .usable    (dir_ok),
        .next_base (dir_next)
    );

    pt_entry_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_LEAF(1'b1)) i_leaf_check (
        .entry     (mem_rsp_data),
        .is_write  (q.write),
        .usable    (leaf_ok),
        .next_base (leaf_next)
    );

    assign entry_ok  = (q.st == WALK_LEAF) ? leaf_ok   : dir_ok;
    assign next_base = (q.st == WALK_LEAF) ? leaf_next : dir_next;

    always_comb begin
        d = q;
        case (q.st)
            WALK_IDLE: begin
                if (req_valid) begin
                    d.write   = req_write;
                    d.va      = req_vaddr;
                    d.issued  = 1'b0;
                    d.fault   = 1'b0;
                    d.bus_err = 1'b0;
                    if (paging_en) begin
                        d.base = dir_frame;
                        d.st   = WALK_DIR;
                    end else begin
                        d.out_addr = req_vaddr;
                        d.st       = WALK_DONE;
                    end
                end
            end
            WALK_DIR, WALK_LEAF: begin
                if (!q.issued && mem_rd_ready) begin
                    d.issued = 1'b1;
                end
                if (q.issued && mem_rsp_valid) begin
                    d.issued = 1'b0;
                    if (mem_rsp_err) begin
                        // an error response wins over whatever the data holds
                        d.bus_err  = 1'b1;
                        d.out_addr = q.va;
                        d.st       = WALK_FAULT;
                    end else if (!entry_ok) begin
                        d.fault    = 1'b1;
                        d.out_addr = q.va;
                        d.st       = WALK_FAULT;
                    end else if (q.st == WALK_DIR) begin
                        d.base = next_base;
                        d.st   = WALK_LEAF;
                    end else begin
                        d.out_addr = {next_base, q.va[PAGE_BITS-1:0]};
                        d.st       = WALK_DONE;
                    end
                end
            end
            default: begin
                // result shown for one cycle, then back to idle
                d.fault   = 1'b0;
                d.bus_err = 1'b0;
                d.st      = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == WALK_IDLE);
    assign mem_rd_valid = ((q.st == WALK_DIR) || (q.st == WALK_LEAF)) && !q.issued;
    assign mem_rd_addr  = (q.st == WALK_LEAF) ? leaf_addr : dir_addr;
    assign rsp_valid    = (q.st == WALK_DONE) || (q.st == WALK_FAULT);
    assign rsp_addr     = q.out_addr;
    assign rsp_write    = q.write;
    assign rsp_fault    = q.fault;
    assign rsp_bus_err  = q.bus_err;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              paging_en,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_fault,
    input logic              rsp_bus_err
);

    p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !paging_en |=>
            rsp_valid && rsp_addr == $past(req_vaddr) && !rsp_fault && !rsp_bus_err);

    p_passthrough_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !paging_en |=> !mem_rd_valid);

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault && rsp_bus_err));

    p_outcome_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_bus_err) |-> rsp_valid);

    p_read_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_while_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready && !mem_rd_valid);

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .paging_en    (paging_en),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_fault    (rsp_fault),
    .rsp_bus_err  (rsp_bus_err)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam int F_SCRAMBLE = 1;
    localparam int F_SPURIOUS = 2;
    localparam int F_BUSY     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        paging_en = 1'b0;
    logic [19:0] dir_frame = 20'h00100;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_write;
    logic        rsp_fault;
    logic        rsp_bus_err;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .paging_en(paging_en), .dir_frame(dir_frame),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_write(rsp_write),
        .rsp_fault(rsp_fault), .rsp_bus_err(rsp_bus_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem_img [logic [31:0]];
    bit          err_img [logic [31:0]];

    bit          exp_rsp = 0;
    logic [31:0] exp_addr;
    bit          exp_fault, exp_bus, exp_wr;
    int          exp_nrd;
    logic [31:0] exp_rd [2];
    string       cur_tag = "R1";

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual cycles=%0d expected below 20000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    function automatic logic [31:0] va(input int d, input int p, input int o);
        logic [9:0]  dd = d[9:0];
        logic [9:0]  pp = p[9:0];
        logic [11:0] oo = o[11:0];
        return {dd, pp, oo};
    endfunction

    // behavioural reference: expected reads and outcome of one request
    task automatic predict(input logic [31:0] v, input bit wr, input bit pg);
        logic [31:0] dte, pte;
        exp_wr = wr; exp_fault = 0; exp_bus = 0; exp_nrd = 0; exp_addr = v;
        if (pg) begin
            exp_rd[0] = {dir_frame, 12'h000} + {20'd0, v[31:22], 2'b00};
            exp_nrd = 1;
            if (err_img.exists(exp_rd[0])) exp_bus = 1;
            else begin
                dte = rd_mem(exp_rd[0]);
                if (!dte[0]) exp_fault = 1;
                else begin
                    exp_rd[1] = {dte[31:12], 12'h000} + {20'd0, v[21:12], 2'b00};
                    exp_nrd = 2;
                    if (err_img.exists(exp_rd[1])) exp_bus = 1;
                    else begin
                        pte = rd_mem(exp_rd[1]);
                        if (!pte[0] || (wr ? !pte[2] : !pte[1])) exp_fault = 1;
                        else exp_addr = {pte[31:12], v[11:0]};
                    end
                end
            end
        end
    endtask

    // compared at every falling edge
    task automatic compare();
        if (exp_rsp) begin
            chk(rsp_valid == 1'b1, {cur_tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'd1);
            chk(rsp_addr == exp_addr, {cur_tag, " R8 rsp_addr"}, rsp_addr, exp_addr);
            chk(rsp_fault == exp_fault, {cur_tag, " R7 rsp_fault"}, 32'(rsp_fault), 32'(exp_fault));
            chk(rsp_bus_err == exp_bus, {cur_tag, " R9 rsp_bus_err"}, 32'(rsp_bus_err), 32'(exp_bus));
            chk(rsp_write == exp_wr, {cur_tag, " R4 rsp_write"}, 32'(rsp_write), 32'(exp_wr));
        end else begin
            chk(rsp_valid == 1'b0, {cur_tag, " R11 no stray rsp"}, 32'(rsp_valid), 32'd0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic walk(input string tag, input logic [31:0] v, input bit wr, input bit pg,
                        input int stall, input int lat, input int flags);
        logic [19:0] saved_frame;
        int guard;
        cur_tag = tag;
        predict(v, wr, pg);
        guard = 0;
        while (!req_ready && guard < 20) begin tick(); guard++; end
        req_valid = 1; req_vaddr = v; req_write = wr; paging_en = pg;
        if (!pg) exp_rsp = 1;
        tick();
        req_valid = 0; exp_rsp = 0;
        saved_frame = dir_frame;
        if ((flags & F_SCRAMBLE) != 0) dir_frame = 20'hF0F0F;
        if ((flags & F_BUSY) != 0) begin
            req_valid = 1; req_vaddr = 32'h0BAD_0000; paging_en = 0;
        end
        if (!pg) chk(mem_rd_valid == 1'b0, {tag, " R2 no read"}, 32'(mem_rd_valid), 32'd0);
        for (int r = 0; r < exp_nrd; r++) begin
            guard = 0;
            while (!mem_rd_valid && guard < 20) begin tick(); guard++; end
            chk(mem_rd_addr == exp_rd[r], {tag, (r == 0) ? " R3 dir addr" : " R5 leaf addr"},
                mem_rd_addr, exp_rd[r]);
            if ((flags & F_SPURIOUS) != 0 && r == 0) begin
                mem_rsp_valid = 1; mem_rsp_err = 1;
                tick();
                mem_rsp_valid = 0; mem_rsp_err = 0;
                chk(mem_rd_valid == 1'b1, {tag, " R10 early rsp ignored"}, 32'(mem_rd_valid), 32'd1);
            end
            for (int s = 0; s < stall; s++) tick();
            mem_rd_ready = 1;
            tick();
            mem_rd_ready = 0;
            chk(mem_rd_valid == 1'b0, {tag, " R10 request dropped after accept"}, 32'(mem_rd_valid), 32'd0);
            for (int l = 0; l < lat; l++) tick();
            mem_rsp_valid = 1;
            mem_rsp_data  = rd_mem(exp_rd[r]);
            mem_rsp_err   = err_img.exists(exp_rd[r]);
            if (r == exp_nrd - 1) exp_rsp = 1;
            tick();
            mem_rsp_valid = 0; mem_rsp_data = '0; mem_rsp_err = 0; exp_rsp = 0;
        end
        dir_frame = saved_frame;
        if ((flags & F_BUSY) != 0) begin
            req_valid = 0; paging_en = 1;
        end
        tick();
        chk(mem_rd_valid == 1'b0, {tag, " R4 R11 no further read"}, 32'(mem_rd_valid), 32'd0);
        chk(req_ready == 1'b1, {tag, " R11 idle again"}, 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid in reset", 32'(mem_rd_valid), 32'd0);
        rst_n = 1;
        tick();
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);

        mem_img[32'h0010_0004] = 32'h0020_0001;
        mem_img[32'h0010_0008] = 32'h0030_0000;
        mem_img[32'h0010_0FFC] = 32'h0040_0001;
        mem_img[32'h0010_0010] = 32'h0000_0000;
        err_img[32'h0010_0010] = 1;
        mem_img[32'h0020_0014] = 32'hABCD_E1FF;
        mem_img[32'h0020_0018] = 32'h1234_5003;
        mem_img[32'h0020_001C] = 32'h5555_5005;
        mem_img[32'h0020_0020] = 32'h6666_6006;
        mem_img[32'h0020_0024] = 32'h0000_0000;
        err_img[32'h0020_0024] = 1;
        mem_img[32'h0020_0FFC] = 32'hFFFF_F007;
        mem_img[32'h0040_0000] = 32'h0000_1007;

        walk("R2 passthrough read",          32'hDEAD_BEEF,      0, 0, 0, 0, 0);
        walk("R2 passthrough write",         32'h0000_1234,      1, 0, 0, 0, 0);
        walk("R8 read ok attrs ignored R7",  va(1, 5, 'h123),    0, 1, 0, 0, 0);
        walk("R8 write ok with stalls",      va(1, 5, 'hFFF),    1, 1, 2, 3, 0);
        walk("R7 read on read-only",         va(1, 6, 'h010),    0, 1, 1, 0, 0);
        walk("R7 write on read-only",        va(1, 6, 'h020),    1, 1, 0, 1, 0);
        walk("R7 write on write-only",       va(1, 7, 'h000),    1, 1, 0, 0, 0);
        walk("R7 read on write-only",        va(1, 7, 'h004),    0, 1, 0, 0, 0);
        walk("R6 invalid leaf",              va(1, 8, 'h000),    1, 1, 0, 0, 0);
        walk("R4 invalid directory",         va(2, 3, 'h055),    1, 1, 0, 2, 0);
        walk("R9 bus error directory",       va(4, 0, 'h000),    0, 1, 1, 1, 0);
        walk("R9 bus error leaf",            va(1, 9, 'h100),    1, 1, 0, 0, 0);
        walk("R5 top directory slot",        va('h3FF, 0, 'hABC), 0, 1, 0, 0, 0);
        walk("R5 top leaf slot",             va(1, 'h3FF, 'hFFF), 0, 1, 0, 0, 0);
        walk("R3 frame latched",             va(1, 5, 'h007),    0, 1, 1, 1, F_SCRAMBLE);
        walk("R10 early response",           va(1, 6, 'h008),    0, 1, 3, 2, F_SPURIOUS);
        walk("R11 busy request held off",    va(1, 7, 'h044),    1, 1, 1, 1, F_BUSY);
        walk("R2 passthrough after walk",    32'h8000_0001,      1, 0, 0, 0, 0);

        summary();
    end
endmodule